// File: doc/BRIEF.md
# Duty-Cycle Comparator Selection Calibrator

This block decides which comparator of a thermometer-ordered bank should act as the slicer for each of the three decision thresholds of a four-level amplitude receiver. A slow strobe, unrelated to the signal rate, samples all comparator outputs together. Each sample counts as one independent yes/no trial of whether a comparator is high. Over a window of 2^CNT_W strobes the block counts, per comparator, how many samples were high. For each threshold it then picks the comparator whose count lies nearest that threshold's target count. The picks follow the real comparator thresholds, so they stay near the eye centre whatever the process corner.

Comparator index grows with threshold voltage, so a higher index means a lower duty. The lowest threshold aims at three quarters high, the middle one at one half and the upper one at one quarter. When the auto input is low, each threshold's channel comes from a field of a manual select word. A level-select input routes one of the three chosen indices to a readback port. A 3-bit state code shows where the controller is.

Top module: `thresh_pick_cal`

## Requirements
- R1: After reset the state code is 0 (idle) and the calibrated index held for every level is 0. These indices are what the level outputs show while auto is high, until the first calibration completes.
- R2: While auto_en is low, level L's output is 3*L plus the unsigned field man_sel[3L+2:3L]. With defaults, level 0 spans channels 0..7, level 1 spans 3..10 and level 2 spans 6..13.
- R3: A calibration window takes exactly 2^CNT_W (128) strobes. A comparator bit is counted only on a cycle where smp_stb is high in the accumulate state. Bank values on other cycles have no effect on the result.
- R4: Each per-channel high counter is CNT_W bits wide and saturates at 2^CNT_W-1 (127). A channel that is high for all 128 samples therefore reads 127 and does not wrap.
- R5: The target counts are 96 for level 0 (lowest threshold), 64 for level 1 and 32 for level 2. Each level picks the channel with the smallest absolute difference between its count and the target.
- R6: When two or more channels are equally near a target, the lowest channel index is chosen.
- R7: The readback output rb_ch shows level 0, 1 or 2's current output for lev_sel = 0, 1 or 2, and shows all ones (15) for lev_sel = 3.
- R8: The state codes are idle 0, clear 1, accumulate 2, compare 3, latch 4 and done 5. With auto high, idle moves to clear and clear moves to accumulate. The edge that takes the final strobe enters compare. Compare lasts NCH (15) cycles, one channel per cycle, then one latch cycle, then done.
- R9: Done holds while auto_en stays high, and further strobes do not start a new window. Lowering auto_en moves any state to idle on the next edge, and the level outputs switch to the manual mapping at once.
- R10: The calibrated indices change only in the latch state. An aborted window leaves the previous results in place, and they reappear when auto_en returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_bank | input | NCH | Comparator outputs, index 0 lowest threshold |
| smp_stb | input | 1 | Sample strobe, one sample per high cycle |
| auto_en | input | 1 | High: self-calibration; low: manual selection |
| man_sel | input | 3*OFS_W | Manual offsets, field L for level L |
| lev_sel | input | 2 | Chooses the level shown on rb_ch |
| lvl0_ch | output | $clog2(NCH) | Channel for the lowest threshold |
| lvl1_ch | output | $clog2(NCH) | Channel for the middle threshold |
| lvl2_ch | output | $clog2(NCH) | Channel for the upper threshold |
| rb_ch | output | $clog2(NCH) | Readback of the selected level's channel |
| state_o | output | 3 | Controller state code |

## Verification
The assertions watch several properties on every cycle. They check that counters saturate rather than wrap, and that counts stay frozen outside strobed accumulate cycles. They also check that the state code stays legal, that dropping auto always forces idle, that readback slot 3 shows all ones, and that calibrated indices move only in the latch state. Only the bench's scenarios can show that the right channel is chosen. It runs whole windows of ramps, reversed ramps built to tie, saturating and all-low banks, and a scrambled spread, and compares each choice against nearest-count selection worked out arithmetically. The exhaustive sweep of the manual word, the latency through compare and latch, and the abort-and-resume behaviour are also shown only by the bench.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    localparam int LEVELS = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_ACCUM = 3'd2,
        ST_CMP   = 3'd3,
        ST_LATCH = 3'd4,
        ST_DONE  = 3'd5
    } cal_state_e;

    // absolute distance between two counts
    function automatic int unsigned gap(input int unsigned a, input int unsigned b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/tpc_duty_bank.sv
module tpc_duty_bank #(
    parameter int NCH   = 15,
    parameter int CNT_W = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      take,
    input  logic [NCH-1:0]            bank,
    output logic [NCH-1:0][CNT_W-1:0] duty
);

    localparam logic [CNT_W-1:0] TOP = '1;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cnt_q <= '0;
            end else if (take && bank[g] && (cnt_q != TOP)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
        assign duty[g] = cnt_q;
    end

endmodule

// File: rtl/tpc_level_search.sv
module tpc_level_search import tpc_pkg::*; #(
    parameter int CNT_W  = 7,
    parameter int IDX_W  = 4,
    parameter int TARGET = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             first,
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] duty,
    output logic [IDX_W-1:0] best
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] err;
    } pick_t;

    pick_t            pick_q;
    logic [CNT_W-1:0] err_now;

    assign err_now = CNT_W'(gap(32'(duty), 32'(TARGET)));

    // strict less-than keeps the earlier (lower) index on a tie
    always_ff @(posedge clk) begin
        if (rst) begin
            pick_q <= '0;
        end else if (step && (first || (err_now < pick_q.err))) begin
            pick_q <= '{idx: idx, err: err_now};
        end
    end

    assign best = pick_q.idx;

endmodule

// File: rtl/thresh_pick_cal.sv
module thresh_pick_cal import tpc_pkg::*; #(
    parameter int NCH   = 15,
    parameter int CNT_W = 7,
    parameter int OFS_W = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCH-1:0]             cmp_bank,
    input  logic                       smp_stb,
    input  logic                       auto_en,
    input  logic [LEVELS*OFS_W-1:0]    man_sel,
    input  logic [1:0]                 lev_sel,
    output logic [$clog2(NCH)-1:0]     lvl0_ch,
    output logic [$clog2(NCH)-1:0]     lvl1_ch,
    output logic [$clog2(NCH)-1:0]     lvl2_ch,
    output logic [$clog2(NCH)-1:0]     rb_ch,
    output logic [2:0]                 state_o
);

    localparam int IDX_W     = $clog2(NCH);
    localparam int WIN       = 1 << CNT_W;
    localparam int BASE_STEP = (NCH - (1 << OFS_W)) / (LEVELS - 1);

    cal_state_e                       st_q;
    logic [CNT_W-1:0]                 smp_cnt_q;
    logic [IDX_W-1:0]                 scan_q;
    logic [LEVELS-1:0][IDX_W-1:0]     cal_q;
    logic [LEVELS-1:0][IDX_W-1:0]     best_idx;
    logic [LEVELS-1:0][IDX_W-1:0]     man_idx;
    logic [LEVELS-1:0][IDX_W-1:0]     sel;
    logic [NCH-1:0][CNT_W-1:0]        duty;
    logic [CNT_W-1:0]                 duty_cur;
    logic                             take;

    assign take     = (st_q == ST_ACCUM) && smp_stb;
    assign duty_cur = duty[scan_q];

    tpc_duty_bank #(.NCH(NCH), .CNT_W(CNT_W)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .clr  (st_q == ST_CLEAR),
        .take (take),
        .bank (cmp_bank),
        .duty (duty)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        tpc_level_search #(
            .CNT_W  (CNT_W),
            .IDX_W  (IDX_W),
            .TARGET ((WIN * (LEVELS - l)) / (LEVELS + 1))
        ) u_srch (
            .clk   (clk),
            .rst   (rst),
            .step  (st_q == ST_CMP),
            .first (scan_q == '0),
            .idx   (scan_q),
            .duty  (duty_cur),
            .best  (best_idx[l])
        );
        assign man_idx[l] = IDX_W'(l * BASE_STEP) + IDX_W'(man_sel[l*OFS_W +: OFS_W]);
        assign sel[l]     = auto_en ? cal_q[l] : man_idx[l];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            smp_cnt_q <= '0;
            scan_q    <= '0;
            cal_q     <= '0;
        end else if (!auto_en) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_q <= ST_CLEAR;
                ST_CLEAR: begin
                    smp_cnt_q <= '0;
                    st_q      <= ST_ACCUM;
                end
                ST_ACCUM: begin
                    if (smp_stb) begin
                        smp_cnt_q <= smp_cnt_q + 1'b1;
                        if (smp_cnt_q == CNT_W'(WIN - 1)) begin
                            scan_q <= '0;
                            st_q   <= ST_CMP;
                        end
                    end
                end
                ST_CMP: begin
                    scan_q <= scan_q + 1'b1;
                    if (scan_q == IDX_W'(NCH - 1)) st_q <= ST_LATCH;
                end
                ST_LATCH: begin
                    cal_q <= best_idx;
                    st_q  <= ST_DONE;
                end
                ST_DONE:  st_q <= ST_DONE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (lev_sel)
            2'd0:    rb_ch = sel[0];
            2'd1:    rb_ch = sel[1];
            2'd2:    rb_ch = sel[2];
            default: rb_ch = '1;
        endcase
    end

    assign lvl0_ch = sel[0];
    assign lvl1_ch = sel[1];
    assign lvl2_ch = sel[2];
    assign state_o = st_q;

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
    parameter int NCH   = 15,
    parameter int CNT_W = 7
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       auto_en,
    input logic                       smp_stb,
    input logic [NCH-1:0]             cmp_bank,
    input logic [1:0]                 lev_sel,
    input logic [$clog2(NCH)-1:0]     rb_ch,
    input logic [2:0]                 state_o,
    input logic [3*$clog2(NCH)-1:0]   cal,
    input logic [NCH*CNT_W-1:0]       duty
);

    localparam logic [2:0] S_IDLE  = 3'd0;
    localparam logic [2:0] S_CLEAR = 3'd1;
    localparam logic [2:0] S_ACCUM = 3'd2;
    localparam logic [2:0] S_LATCH = 3'd4;
    localparam logic [2:0] S_DONE  = 3'd5;

    a_r8_legal_state: assert property (@(posedge clk) disable iff (rst)
        state_o <= S_DONE);

    a_r8_idle_to_clear: assert property (@(posedge clk) disable iff (rst)
        (state_o == S_IDLE && auto_en) |=> (state_o == S_CLEAR));

    a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> (state_o == S_IDLE));

    a_r7_spare_slot: assert property (@(posedge clk) disable iff (rst)
        (lev_sel == 2'd3) |-> (rb_ch == '1));

    a_r10_cal_hold: assert property (@(posedge clk) disable iff (rst)
        (state_o != S_LATCH) |=> $stable(cal));

    a_r3_frozen_counts: assert property (@(posedge clk) disable iff (rst)
        (state_o != S_CLEAR && !(state_o == S_ACCUM && smp_stb)) |=> $stable(duty));

    for (genvar g = 0; g < NCH; g++) begin : g_sat
        a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
            (state_o == S_ACCUM && smp_stb && cmp_bank[g] && duty[g*CNT_W +: CNT_W] == '1)
            |=> (duty[g*CNT_W +: CNT_W] == '1));
    end

endmodule

bind thresh_pick_cal tpc_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .auto_en  (auto_en),
    .smp_stb  (smp_stb),
    .cmp_bank (cmp_bank),
    .lev_sel  (lev_sel),
    .rb_ch    (rb_ch),
    .state_o  (state_o),
    .cal      (cal_q),
    .duty     (duty)
);

// File: tb/sim_thresh_pick_cal.sv
module sim_thresh_pick_cal;

    localparam int NCH   = 15;
    localparam int CNT_W = 7;
    localparam int OFS_W = 3;
    localparam int WIN   = 1 << CNT_W;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] cmp_bank = '0;
    logic           smp_stb = 1'b0;
    logic           auto_en = 1'b0;
    logic [8:0]     man_sel = '0;
    logic [1:0]     lev_sel = '0;
    logic [3:0]     lvl0_ch, lvl1_ch, lvl2_ch, rb_ch;
    logic [2:0]     state_o;

    int checks = 0;
    int errs   = 0;

    always #5 clk = ~clk;

    thresh_pick_cal #(.NCH(NCH), .CNT_W(CNT_W), .OFS_W(OFS_W)) u0 (
        .clk(clk), .rst(rst), .cmp_bank(cmp_bank), .smp_stb(smp_stb),
        .auto_en(auto_en), .man_sel(man_sel), .lev_sel(lev_sel),
        .lvl0_ch(lvl0_ch), .lvl1_ch(lvl1_ch), .lvl2_ch(lvl2_ch),
        .rb_ch(rb_ch), .state_o(state_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // number of window samples for which channel i is high, per pattern
    function automatic int hi_of(input int p, input int i);
        case (p)
            0: return WIN - 8 * (i + 1);
            1: return 8 * i + 4;
            2: return WIN;
            3: return 0;
            4: return (i == 0) ? WIN : ((i == 1) ? 65 : 64);
            default: return (i * 37 + 11) % (WIN + 1);
        endcase
    endfunction

    function automatic int exp_sel(input int p, input int l);
        int t = (WIN * (3 - l)) / 4;
        int best = 0;
        int bd = 1 << 20;
        for (int i = 0; i < NCH; i++) begin
            int d = hi_of(p, i);
            int e;
            if (d > WIN - 1) d = WIN - 1;
            e = (d > t) ? d - t : t - d;
            if (e < bd) begin
                bd = e;
                best = i;
            end
        end
        return best;
    endfunction

    task automatic run_cal(input int p);
        auto_en = 1'b0;
        @(negedge clk);
        auto_en = 1'b1;
        @(negedge clk);
        chk("R8 clear state", state_o, 1);
        @(negedge clk);
        chk("R8 accumulate state", state_o, 2);
        for (int s = 0; s < WIN; s++) begin
            for (int i = 0; i < NCH; i++) cmp_bank[i] = (s < hi_of(p, i));
            smp_stb = 1'b1;
            @(negedge clk);
            smp_stb = 1'b0;
            cmp_bank = ~cmp_bank;   // R3: must not count
            if (s < WIN - 1) @(negedge clk);
        end
        chk("R8 compare after last strobe", state_o, 3);
        repeat (14) @(negedge clk);
        chk("R8 compare spans NCH cycles", state_o, 3);
        @(negedge clk);
        chk("R8 latch state", state_o, 4);
        @(negedge clk);
        chk("R8 done state", state_o, 5);
        chk("R5 R6 level0 pick", lvl0_ch, exp_sel(p, 0));
        chk("R5 R6 level1 pick", lvl1_ch, exp_sel(p, 1));
        chk("R5 R6 level2 pick", lvl2_ch, exp_sel(p, 2));
        for (int l = 0; l < 3; l++) begin
            lev_sel = 2'(l);
            #1;
            chk("R7 readback calibrated", rb_ch, exp_sel(p, l));
        end
        // R9: strobes in done do nothing
        for (int k = 0; k < 6; k++) begin
            cmp_bank = '1;
            smp_stb = 1'b1;
            @(negedge clk);
        end
        smp_stb = 1'b0;
        chk("R9 done holds", state_o, 5);
        chk("R9 picks unchanged", lvl1_ch, exp_sel(p, 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset state", state_o, 0);
        chk("R2 reset manual level0", lvl0_ch, 0);
        chk("R2 reset manual level2", lvl2_ch, 6);

        // R2 / R7: exhaustive manual word sweep
        for (int m = 0; m < 512; m++) begin
            man_sel = 9'(m);
            lev_sel = 2'(m % 4);
            #1;
            chk("R2 manual level0", lvl0_ch, 0 + (m & 7));
            chk("R2 manual level1", lvl1_ch, 3 + ((m >> 3) & 7));
            chk("R2 manual level2", lvl2_ch, 6 + ((m >> 6) & 7));
            case (m % 4)
                0: chk("R7 readback manual", rb_ch, 0 + (m & 7));
                1: chk("R7 readback manual", rb_ch, 3 + ((m >> 3) & 7));
                2: chk("R7 readback manual", rb_ch, 6 + ((m >> 6) & 7));
                default: chk("R7 readback spare", rb_ch, 15);
            endcase
        end
        @(negedge clk);
        man_sel = 9'h1FF;

        // R1: calibrated indices are zero before any calibration
        auto_en = 1'b1;
        #1;
        chk("R1 cal level0 zero", lvl0_ch, 0);
        chk("R1 cal level1 zero", lvl1_ch, 0);
        chk("R1 cal level2 zero", lvl2_ch, 0);

        for (int p = 0; p < 6; p++) run_cal(p);

        // R9 / R10: abort mid-window keeps the previous results
        auto_en = 1'b0;
        @(negedge clk);
        auto_en = 1'b1;
        repeat (2) @(negedge clk);
        for (int s = 0; s < 20; s++) begin
            cmp_bank = '0;
            smp_stb = 1'b1;
            @(negedge clk);
        end
        smp_stb = 1'b0;
        chk("R9 still accumulating", state_o, 2);
        auto_en = 1'b0;
        #1;
        chk("R9 manual at once level0", lvl0_ch, 7);
        chk("R9 manual at once level2", lvl2_ch, 13);
        @(negedge clk);
        chk("R9 abort to idle", state_o, 0);
        auto_en = 1'b1;
        #1;
        chk("R10 level0 kept", lvl0_ch, exp_sel(5, 0));
        chk("R10 level1 kept", lvl1_ch, exp_sel(5, 1));
        chk("R10 level2 kept", lvl2_ch, exp_sel(5, 2));
        lev_sel = 2'd3;
        #1;
        chk("R7 spare slot", rb_ch, 15);
        @(negedge clk);
        chk("R8 idle to clear", state_o, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule